// File: doc/BRIEF.md
# External Interrupt Request Flags

This block turns asynchronous, active-low interrupt request pins into pending flags for an interrupt controller. Every line has its own trigger select, chosen by software. In one setting a falling edge on the pin raises the flag. In the other setting the flag is raised on every cycle in which the pin is seen low. The flag stays set until the controller acknowledges the request or software writes the flag. When the pin is still low in level mode, the flag is raised again after an acknowledge.

Each pin first passes through a chain of synchronising flip-flops. Falling edges are detected on the synchronised signal. A detection always takes priority over a clear that happens in the same cycle, so no request is lost. With the default two-stage chain, a change on a pin shows up on its pending flag three clock edges later. The lines do not share any state.

Top module: `eint_lines`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, every `pend` bit is 0. The synchroniser and the edge history reset to the idle-high pin level.
- R2: With `trig_fall[i]`=1, a high-to-low change on `irq_n[i]` sets `pend[i]`. It becomes visible SYNC_STAGES+1 rising edges after the pin is first sampled low, and not earlier.
- R3: With `trig_fall[i]`=0, `pend[i]` becomes 1 SYNC_STAGES+1 rising edges after `irq_n[i]` is first sampled low. It is set again on every cycle in which the synchronised pin is low, including the cycle of an acknowledge.
- R4: A one-cycle `ack[i]` pulse with no detection in the same cycle clears `pend[i]` on the next edge.
- R5: A `sw_wr[i]` pulse loads `sw_data[i]` into `pend[i]` on the next edge. Writing 1 sets the flag and writing 0 clears it. Such a write takes priority over `ack[i]`.
- R6: A detection in the same cycle as an acknowledge or a software clear leaves `pend[i]` at 1.
- R7: Changing `trig_fall[i]` while the pin stays high does not set `pend[i]`.
- R8: In edge mode, a rising edge, or a pin held low after the flag was cleared, does not set `pend[i]`.
- R9: Stimulus on one line leaves the `pend` bits of the other lines unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_n | input | N_LINES | Asynchronous active-low request pins |
| trig_fall | input | N_LINES | Trigger select per line: 1 = falling edge, 0 = low level |
| ack | input | N_LINES | Acknowledge strobe from the interrupt controller |
| sw_wr | input | N_LINES | Software write strobe for the flag |
| sw_data | input | N_LINES | Value written to the flag by software |
| pend | output | N_LINES | Registered pending flags |

## Verification
The bench builds the block with its defaults: two lines and a two-stage synchroniser. This gives a fixed pin-to-flag latency of three edges. With so few lines, the bench can sweep every pairing of line and trigger mode. For each pairing it runs the full sequence: idle type toggling, assertion of the pin, acknowledge, release, software set and clear, and a detection that collides with both clears. In every step it checks that the other line stays quiet.

// File: rtl/eint_pkg.sv
package eint_pkg;

  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_FALL  = 1'b1
  } trig_e;

  // Detection condition from the previous and current synchronised samples
  function automatic logic trig_hit(trig_e mode, logic prev_s, logic cur_s);
    if (mode == TRIG_FALL) return prev_s & ~cur_s;
    return ~cur_s;
  endfunction

endpackage

// File: rtl/eint_sync.sv
module eint_sync #(
  parameter int STAGES  = 2,
  parameter bit IDLE_LV = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= {STAGES{IDLE_LV}};
    else     chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];

  initial begin
    if (STAGES < 2) $error("eint_sync needs at least two stages");
  end
endmodule

// File: rtl/eint_detect.sv
module eint_detect
  import eint_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic pin_s,
  input  logic trig_fall,
  input  logic ack,
  input  logic sw_wr,
  input  logic sw_data,
  output logic pend
);
  trig_e mode;
  logic  prev_q;
  logic  hit;
  logic  pend_q;
  logic  pend_d;

  assign mode = trig_e'(trig_fall);
  assign hit  = trig_hit(mode, prev_q, pin_s);

  always_comb begin
    pend_d = pend_q;
    if (sw_wr)    pend_d = sw_data;
    else if (ack) pend_d = 1'b0;
    if (hit)      pend_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      prev_q <= pin_s;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;

  // R2: falling edge in edge mode sets the flag
  p_edge_sets_r2: assert property (@(posedge clk) disable iff (rst)
    (trig_fall && prev_q && !pin_s) |=> pend);

  // R3: low sample in level mode sets the flag
  p_level_sets_r3: assert property (@(posedge clk) disable iff (rst)
    (!trig_fall && !pin_s) |=> pend);

  // R4: acknowledge without detection clears
  p_ack_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (ack && !sw_wr && pin_s) |=> !pend);

  // R5: software write loads the value when no detection can occur
  p_sw_loads_r5: assert property (@(posedge clk) disable iff (rst)
    (sw_wr && pin_s) |=> (pend == $past(sw_data)));

  // R7: with pin high and no writes, a clear flag stays clear
  p_no_spurious_r7: assert property (@(posedge clk) disable iff (rst)
    (!pend && pin_s && !sw_wr) |=> !pend);

  // R6: a set flag stays set unless a clear request occurs
  p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (pend && !ack && !sw_wr) |=> pend);
endmodule

// File: rtl/eint_lines.sv
module eint_lines #(
  parameter int N_LINES     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] irq_n,
  input  logic [N_LINES-1:0] trig_fall,
  input  logic [N_LINES-1:0] ack,
  input  logic [N_LINES-1:0] sw_wr,
  input  logic [N_LINES-1:0] sw_data,
  output logic [N_LINES-1:0] pend
);
  logic [N_LINES-1:0] pin_s;

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    eint_sync #(
      .STAGES (SYNC_STAGES),
      .IDLE_LV(1'b1)
    ) u_sync (
      .clk(clk),
      .rst(rst),
      .d  (irq_n[i]),
      .q  (pin_s[i])
    );

    eint_detect u_det (
      .clk      (clk),
      .rst      (rst),
      .pin_s    (pin_s[i]),
      .trig_fall(trig_fall[i]),
      .ack      (ack[i]),
      .sw_wr    (sw_wr[i]),
      .sw_data  (sw_data[i]),
      .pend     (pend[i])
    );
  end

  // R1: flags are clear on the first cycle after reset
  p_reset_clear_r1: assert property (@(posedge clk)
    $fell(rst) |-> (pend == '0));

  // R9: a line whose pin stays high and gets no write cannot rise
  p_line_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (pin_s[0] && !sw_wr[0] && !pend[0]) |=> !pend[0]);
endmodule

// File: tb/eint_lines_bench.sv
module eint_lines_bench;
  localparam int N   = 2;
  localparam int SS  = 2;
  localparam int LAT = SS + 1;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] irq_n, trig_fall, ack, sw_wr, sw_data;
  logic [N-1:0] pend;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  eint_lines #(.N_LINES(N), .SYNC_STAGES(SS)) u_eint_lines (
    .clk(clk), .rst(rst), .irq_n(irq_n), .trig_fall(trig_fall),
    .ack(ack), .sw_wr(sw_wr), .sw_data(sw_data), .pend(pend)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Check the other lines stay at zero
  task automatic chk_others(input int ln, input string req);
    for (int k = 0; k < N; k++)
      if (k != ln) chk(pend[k], 1'b0, req);
  endtask

  task automatic run_case(input int ln, input logic mode);
    string r_set;
    r_set = mode ? "R2" : "R3";
    irq_n = '1; ack = '0; sw_wr = '0; sw_data = '0; trig_fall = '0;
    trig_fall[ln] = mode;
    rst = 1'b1;
    step(2);
    chk(pend[ln], 1'b0, "R1 pend during reset");
    rst = 1'b0;
    step(1);
    chk(pend[ln], 1'b0, "R1 pend after reset");
    // R7: toggle type bit with pin high
    for (int t = 0; t < 4; t++) begin
      trig_fall[ln] = ~trig_fall[ln];
      step(1);
    end
    trig_fall[ln] = mode;
    step(2);
    chk(pend[ln], 1'b0, "R7 type change with pin high");
    // Assert pin; latency check
    irq_n[ln] = 1'b0;
    step(LAT - 1);
    chk(pend[ln], 1'b0, {r_set, " not before latency"});
    step(1);
    chk(pend[ln], 1'b1, {r_set, " set at latency"});
    chk_others(ln, "R9 other line quiet");
    // Acknowledge with pin still low
    ack[ln] = 1'b1;
    step(1);
    ack[ln] = 1'b0;
    if (mode) chk(pend[ln], 1'b0, "R4 ack clears in edge mode");
    else      chk(pend[ln], 1'b1, "R3 level re-sets on ack");
    step(3);
    if (mode) chk(pend[ln], 1'b0, "R8 held low no re-set");
    else      chk(pend[ln], 1'b1, "R3 level stays set");
    // Release pin
    irq_n[ln] = 1'b1;
    step(LAT + 1);
    ack[ln] = 1'b1;
    step(1);
    ack[ln] = 1'b0;
    chk(pend[ln], 1'b0, "R4 ack clears with pin high");
    step(2);
    chk(pend[ln], 1'b0, mode ? "R8 rising edge ignored" : "R4 stays clear");
    // Software write 1 then 0, with ack in the same cycle as the set
    sw_wr[ln] = 1'b1; sw_data[ln] = 1'b1; ack[ln] = 1'b1;
    step(1);
    sw_wr[ln] = 1'b0; ack[ln] = 1'b0;
    chk(pend[ln], 1'b1, "R5 write 1 sets over ack");
    sw_wr[ln] = 1'b1; sw_data[ln] = 1'b0;
    step(1);
    sw_wr[ln] = 1'b0;
    chk(pend[ln], 1'b0, "R5 write 0 clears");
    chk_others(ln, "R9 other line quiet after writes");
    // R6: detection collides with ack and software clear
    sw_wr[ln] = 1'b1; sw_data[ln] = 1'b1;
    step(1);
    sw_wr[ln] = 1'b0;
    irq_n[ln] = 1'b0;
    step(LAT - 1);
    ack[ln] = 1'b1; sw_wr[ln] = 1'b1; sw_data[ln] = 1'b0;
    step(1);
    ack[ln] = 1'b0; sw_wr[ln] = 1'b0;
    chk(pend[ln], 1'b1, "R6 detection beats clear");
    irq_n[ln] = 1'b1;
    step(LAT + 1);
    sw_wr[ln] = 1'b1; sw_data[ln] = 1'b0;
    step(1);
    sw_wr[ln] = 1'b0;
    chk(pend[ln], 1'b0, "R5 final clear");
  endtask

  initial begin
    rst = 1'b1;
    irq_n = '1; trig_fall = '0; ack = '0; sw_wr = '0; sw_data = '0;
    for (int ln = 0; ln < N; ln++)
      for (int m = 0; m < 2; m++)
        run_case(ln, m[0]);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule